// File: doc/BRIEF.md
# Lockable Four-Way Data Cache

This block is a 16 KB data cache placed between a processor load-store port that moves 64-bit doublewords and a bus master port that moves 32-bit words. The processor issues one request at a time: a load, a store, a prefetch, a lock or an unlock. Every request carries two page attributes. One says whether the access may use the cache at all. The other, for stores, says whether the bus is updated at once (write-through) or only the cached copy is marked modified (writeback).

Storage is 128 sets of four ways with 32-byte lines. Line fills and write-backs of modified lines are bursts of eight bus words. A new line is brought in only for read-type requests: load, prefetch and lock. A store that misses goes straight to the bus. Recency of use is tracked per set. Any single line can be pinned with the lock request so that it is never replaced. When a set has every way pinned, read misses to that set are served from the bus without allocating a line.

Top module: `dc_top`

## Requirements
- R1: The address splits into tag = bits 31:12, set = bits 11:5 and doubleword-in-line = bits 4:3. Bits 2:0 are ignored. Within a line, bus word n sits at line base + 4n, and doubleword k is formed from word 2k (bits 31:0) and word 2k+1 (bits 63:32).
- R2: A cacheable load (`cpu_op` = 0) that hits returns the addressed doubleword with no bus traffic and with `cpu_hit` = 1. Every request is answered by a one-cycle `cpu_ready` pulse, and all outputs are low after reset.
- R3: A cacheable read-type miss with a usable victim reads the whole line as an 8-word burst at ascending addresses from the line base, then answers with `cpu_hit` = 0. For a load, it returns the requested data.
- R4: If the chosen victim is valid and modified, it is first written back as an 8-word write burst at its own line address, and only then is the line refilled.
- R5: The victim is the lowest-numbered way that is unlocked and invalid. If there is none, it is the unlocked valid way used least recently. A hit by a load, store, prefetch or lock counts as a use, and so does the lookup that follows a fill.
- R6: A cacheable store (`cpu_op` = 1) that hits updates the line. With `cpu_wthru` = 1 it also writes two bus words (low half at the doubleword address, high half at +4). With `cpu_wthru` = 0 it marks the line modified and makes no bus access.
- R7: A cacheable store that misses writes two bus words and allocates no line, so a later load to that line misses.
- R8: With `cpu_cacheable` = 0, a load reads two bus words and a store writes two bus words, the arrays are not touched, and `cpu_hit` = 0. Prefetch, lock and unlock with `cpu_cacheable` = 0 make no bus access.
- R9: A prefetch (`cpu_op` = 2) fills a line exactly as a load does, but `cpu_rdata` keeps its previous value.
- R10: A lock request (`cpu_op` = 3) fills the line if it is absent and then pins it. A pinned line is never chosen as victim. An unlock request (`cpu_op` = 4) unpins the line on a hit, makes no bus access, and has no effect on a miss.
- R11: When all four ways of the set are pinned, a load miss reads two bus words without allocating, and a prefetch or lock miss makes no bus access.
- R12: Once `bus_req` is raised, it stays high with `bus_addr`, `bus_we` and `bus_wdata` stable until `bus_ack`. Each cycle with `bus_req` and `bus_ack` both high moves one word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Request strobe, taken when the cache is idle |
| cpu_op | input | 3 | 0 load, 1 store, 2 prefetch, 3 lock, 4 unlock |
| cpu_addr | input | 32 | Byte address of the doubleword |
| cpu_wdata | input | 64 | Store data |
| cpu_cacheable | input | 1 | Page attribute: access may use the cache |
| cpu_wthru | input | 1 | Page attribute: store updates the bus at once |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_hit | output | 1 | Request was satisfied by its first lookup |
| cpu_rdata | output | 64 | Load data |
| bus_req | output | 1 | Bus word transfer request |
| bus_we | output | 1 | Transfer is a write |
| bus_addr | output | 32 | Word address of the transfer |
| bus_wdata | output | 32 | Write word |
| bus_ack | input | 1 | Word accepted or returned this cycle |
| bus_rdata | input | 32 | Read word |

## Verification
The hardest state to reach from the ports is a set that is full of modified lines with some ways pinned. Only there do write-back ordering, victim skipping and the all-pinned bypass show up. Random traffic is therefore confined to two sets and six tags, and mixes lock and unlock requests with writeback stores, so that sets stay full and modified all the time. A directed sequence pins every way of a third set before missing into it, then releases one way and misses again. The bus acknowledges at random, so every burst also stalls in the middle.

// File: rtl/dc_pkg.sv
package dc_pkg;

    typedef enum logic [2:0] {
        OP_LOAD   = 3'd0,
        OP_STORE  = 3'd1,
        OP_PREF   = 3'd2,
        OP_LOCK   = 3'd3,
        OP_UNLOCK = 3'd4
    } op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LOOK,
        S_EVICT,
        S_FILL,
        S_BUS
    } st_e;

    typedef struct packed {
        logic valid;
        logic dirty;
        logic locked;
    } meta_t;

    // Requests that may bring a line into the cache
    function automatic logic is_read_op(op_e op);
        return (op == OP_LOAD) || (op == OP_PREF) || (op == OP_LOCK);
    endfunction

endpackage

// File: rtl/dc_lru.sv
module dc_lru #(
    parameter int SETS = 128,
    parameter int WAYS = 4,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SET_W-1:0] set_i,
    input  logic             touch_i,
    input  logic [WAY_W-1:0] touch_way_i,
    input  logic [WAYS-1:0]  valid_i,
    input  logic [WAYS-1:0]  lock_i,
    output logic [WAY_W-1:0] vic_way_o,
    output logic             vic_ok_o
);
    // Per-way age: 0 = most recent, WAYS-1 = oldest
    logic [WAY_W-1:0] age_q [SETS][WAYS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++)
                    age_q[s][w] <= WAY_W'(w);
        end else if (touch_i) begin
            for (int w = 0; w < WAYS; w++) begin
                if (WAY_W'(w) == touch_way_i)
                    age_q[set_i][w] <= '0;
                else if (age_q[set_i][w] < age_q[set_i][touch_way_i])
                    age_q[set_i][w] <= age_q[set_i][w] + 1'b1;
            end
        end
    end

    always_comb begin
        logic found_inv;
        logic [WAY_W-1:0] best;
        found_inv = 1'b0;
        vic_ok_o  = 1'b0;
        vic_way_o = '0;
        best      = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!lock_i[w] && !valid_i[w]) begin
                found_inv = 1'b1;
                vic_way_o = WAY_W'(w);
            end
        end
        if (found_inv) begin
            vic_ok_o = 1'b1;
        end else begin
            for (int w = 0; w < WAYS; w++) begin
                if (!lock_i[w] && (!vic_ok_o || age_q[set_i][w] > best)) begin
                    vic_ok_o  = 1'b1;
                    vic_way_o = WAY_W'(w);
                    best      = age_q[set_i][w];
                end
            end
        end
    end

endmodule

// File: rtl/dc_burst.sv
module dc_burst #(
    parameter int ADDR_W = 32,
    parameter int BUS_W  = 32,
    parameter int WPL    = 8,
    localparam int IDX_W = $clog2(WPL),
    localparam int LEN_W = IDX_W + 1,
    localparam int BB_W  = $clog2(BUS_W / 8)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic [LEN_W-1:0]  start_len_i,
    input  logic              start_we_i,
    input  logic              bus_ack,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [IDX_W-1:0]  idx_o,
    output logic              done_o
);
    logic [ADDR_W-1:0] base_q;
    logic [LEN_W-1:0]  len_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_req <= 1'b0;
            bus_we  <= 1'b0;
            base_q  <= '0;
            len_q   <= '0;
            idx_o   <= '0;
        end else if (start_i) begin
            bus_req <= 1'b1;
            bus_we  <= start_we_i;
            base_q  <= start_addr_i;
            len_q   <= start_len_i;
            idx_o   <= '0;
        end else if (bus_req && bus_ack) begin
            if (done_o) bus_req <= 1'b0;
            else        idx_o   <= idx_o + 1'b1;
        end
    end

    assign done_o   = bus_req && bus_ack && ({1'b0, idx_o} == len_q - 1'b1);
    assign bus_addr = base_q + ADDR_W'({idx_o, {BB_W{1'b0}}});

    // R12: a stalled transfer keeps its request, address and direction
    assert_bus_hold_R12: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)));

endmodule

// File: rtl/dc_top.sv
module dc_top
    import dc_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int CPU_W      = 64,
    parameter int BUS_W      = 32,
    parameter int CAP_BYTES  = 16384,
    parameter int WAYS       = 4,
    parameter int LINE_BYTES = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic [2:0]        cpu_op,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [CPU_W-1:0]  cpu_wdata,
    input  logic              cpu_cacheable,
    input  logic              cpu_wthru,
    output logic              cpu_ready,
    output logic              cpu_hit,
    output logic [CPU_W-1:0]  cpu_rdata,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [BUS_W-1:0]  bus_wdata,
    input  logic              bus_ack,
    input  logic [BUS_W-1:0]  bus_rdata
);
    localparam int SETS   = CAP_BYTES / (WAYS * LINE_BYTES);
    localparam int WPL    = LINE_BYTES / (BUS_W / 8);
    localparam int DPL    = LINE_BYTES / (CPU_W / 8);
    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int SET_W  = $clog2(SETS);
    localparam int TAG_W  = ADDR_W - SET_W - OFF_W;
    localparam int DW_W   = $clog2(DPL);
    localparam int BOFF_W = $clog2(CPU_W / 8);
    localparam int WAY_W  = $clog2(WAYS);
    localparam int IDX_W  = $clog2(WPL);
    localparam int LEN_W  = IDX_W + 1;

    st_e st_q, st_d;
    op_e op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [CPU_W-1:0]  wdata_q;
    logic cach_q, wt_q, missed_q;
    logic [WAY_W-1:0] way_q;

    meta_t            meta_q [SETS][WAYS];
    logic [TAG_W-1:0] tag_q  [SETS][WAYS];
    logic [CPU_W-1:0] data_q [SETS][WAYS][DPL];

    logic [SET_W-1:0] set_idx;
    logic [TAG_W-1:0] tag_in;
    logic [DW_W-1:0]  dw_idx;
    assign set_idx = addr_q[OFF_W +: SET_W];
    assign tag_in  = addr_q[ADDR_W-1 -: TAG_W];
    assign dw_idx  = addr_q[BOFF_W +: DW_W];

    // Tag compare across the ways of the addressed set
    logic hit, hit_eff;
    logic [WAY_W-1:0] hway;
    logic [WAYS-1:0] valid_v, lock_v;
    always_comb begin
        hit  = 1'b0;
        hway = '0;
        for (int w = 0; w < WAYS; w++) begin
            valid_v[w] = meta_q[set_idx][w].valid;
            lock_v[w]  = meta_q[set_idx][w].locked;
            if (meta_q[set_idx][w].valid && tag_q[set_idx][w] == tag_in) begin
                hit  = 1'b1;
                hway = WAY_W'(w);
            end
        end
    end
    assign hit_eff = cach_q && hit;

    logic [WAY_W-1:0] vic_way;
    logic vic_ok, touch;
    assign touch = (st_q == S_LOOK) && hit_eff && (op_q != OP_UNLOCK);

    dc_lru #(.SETS(SETS), .WAYS(WAYS)) u_lru (
        .clk(clk), .rst(rst), .set_i(set_idx), .touch_i(touch), .touch_way_i(hway),
        .valid_i(valid_v), .lock_i(lock_v), .vic_way_o(vic_way), .vic_ok_o(vic_ok)
    );

    logic bs_start, bs_we, bs_done;
    logic [ADDR_W-1:0] bs_addr;
    logic [LEN_W-1:0]  bs_len;
    logic [IDX_W-1:0]  bs_idx;

    dc_burst #(.ADDR_W(ADDR_W), .BUS_W(BUS_W), .WPL(WPL)) u_burst (
        .clk(clk), .rst(rst), .start_i(bs_start), .start_addr_i(bs_addr),
        .start_len_i(bs_len), .start_we_i(bs_we), .bus_ack(bus_ack),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .idx_o(bs_idx), .done_o(bs_done)
    );

    logic [ADDR_W-1:0] line_base, dw_base, vic_base;
    assign line_base = {addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    assign dw_base   = {addr_q[ADDR_W-1:BOFF_W], {BOFF_W{1'b0}}};
    assign vic_base  = {tag_q[set_idx][vic_way], set_idx, {OFF_W{1'b0}}};

    logic finish;
    always_comb begin
        st_d     = st_q;
        finish   = 1'b0;
        bs_start = 1'b0;
        bs_addr  = line_base;
        bs_len   = LEN_W'(WPL);
        bs_we    = 1'b0;
        case (st_q)
            S_IDLE: if (cpu_req) st_d = S_LOOK;
            S_LOOK: begin
                if (!cach_q || (op_q == OP_STORE && (!hit || wt_q))) begin
                    if (op_q == OP_LOAD || op_q == OP_STORE) begin
                        bs_start = 1'b1;
                        bs_addr  = dw_base;
                        bs_len   = LEN_W'(2);
                        bs_we    = (op_q == OP_STORE);
                        st_d     = S_BUS;
                    end else begin
                        finish = 1'b1;
                    end
                end else if (hit || !is_read_op(op_q)) begin
                    finish = 1'b1;
                end else if (vic_ok) begin
                    bs_start = 1'b1;
                    if (meta_q[set_idx][vic_way].valid && meta_q[set_idx][vic_way].dirty) begin
                        bs_addr = vic_base;
                        bs_we   = 1'b1;
                        st_d    = S_EVICT;
                    end else begin
                        st_d = S_FILL;
                    end
                end else if (op_q == OP_LOAD) begin
                    bs_start = 1'b1;
                    bs_addr  = dw_base;
                    bs_len   = LEN_W'(2);
                    st_d     = S_BUS;
                end else begin
                    finish = 1'b1;
                end
            end
            S_EVICT: if (bs_done) begin
                bs_start = 1'b1;
                st_d     = S_FILL;
            end
            S_FILL: if (bs_done) st_d = S_LOOK;
            S_BUS:  if (bs_done) finish = 1'b1;
            default: st_d = S_IDLE;
        endcase
        if (finish) st_d = S_IDLE;
    end

    always_comb begin
        if (st_q == S_EVICT)
            bus_wdata = data_q[set_idx][way_q][bs_idx[IDX_W-1:1]][bs_idx[0]*BUS_W +: BUS_W];
        else
            bus_wdata = wdata_q[bs_idx[0]*BUS_W +: BUS_W];
    end

    // Control, request capture and processor-side outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= S_IDLE;
            op_q      <= OP_LOAD;
            addr_q    <= '0;
            wdata_q   <= '0;
            cach_q    <= 1'b0;
            wt_q      <= 1'b0;
            missed_q  <= 1'b0;
            way_q     <= '0;
            cpu_ready <= 1'b0;
            cpu_hit   <= 1'b0;
            cpu_rdata <= '0;
        end else begin
            st_q      <= st_d;
            cpu_ready <= finish;
            if (st_q == S_IDLE && cpu_req) begin
                op_q     <= op_e'(cpu_op);
                addr_q   <= cpu_addr;
                wdata_q  <= cpu_wdata;
                cach_q   <= cpu_cacheable;
                wt_q     <= cpu_wthru;
                missed_q <= 1'b0;
            end
            if (st_q == S_LOOK) begin
                way_q <= vic_way;
                if (!hit_eff) missed_q <= 1'b1;
                if (hit_eff && op_q == OP_LOAD) cpu_rdata <= data_q[set_idx][hway][dw_idx];
            end
            if (st_q == S_BUS && !bus_we && bus_req && bus_ack)
                cpu_rdata[bs_idx[0]*BUS_W +: BUS_W] <= bus_rdata;
            if (finish)
                cpu_hit <= (st_q == S_LOOK) ? (hit_eff && !missed_q) : !missed_q;
        end
    end

    // Line state: valid, modified, pinned
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++)
                    meta_q[s][w] <= '0;
        end else if (st_q == S_LOOK && hit_eff) begin
            case (op_q)
                OP_STORE:  if (!wt_q) meta_q[set_idx][hway].dirty <= 1'b1;
                OP_LOCK:   meta_q[set_idx][hway].locked <= 1'b1;
                OP_UNLOCK: meta_q[set_idx][hway].locked <= 1'b0;
                default: ;
            endcase
        end else if (st_q == S_FILL && bs_done) begin
            meta_q[set_idx][way_q] <= '{valid: 1'b1, dirty: 1'b0, locked: 1'b0};
        end
    end

    // Tag and data arrays
    always_ff @(posedge clk) begin
        if (st_q == S_LOOK && hit_eff && op_q == OP_STORE)
            data_q[set_idx][hway][dw_idx] <= wdata_q;
        if (st_q == S_FILL && bus_req && bus_ack)
            data_q[set_idx][way_q][bs_idx[IDX_W-1:1]][bs_idx[0]*BUS_W +: BUS_W] <= bus_rdata;
        if (st_q == S_FILL && bs_done)
            tag_q[set_idx][way_q] <= tag_in;
    end

    assert_ready_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        cpu_ready |=> !cpu_ready);

    assert_evict_then_fill_R4: assert property (@(posedge clk) disable iff (rst)
        (st_q == S_EVICT && bs_done) |=> (st_q == S_FILL && bus_req && !bus_we));

    assert_store_no_alloc_R7: assert property (@(posedge clk) disable iff (rst)
        (st_q == S_LOOK && op_q == OP_STORE) |=> (st_q != S_FILL && st_q != S_EVICT));

    assert_uncached_bypass_R8: assert property (@(posedge clk) disable iff (rst)
        (st_q == S_LOOK && !cach_q) |=> (st_q == S_BUS || st_q == S_IDLE));

    assert_victim_unlocked_R10: assert property (@(posedge clk) disable iff (rst)
        (st_q == S_LOOK && hit_eff == 1'b0 && cach_q && is_read_op(op_q) && vic_ok)
            |-> !meta_q[set_idx][vic_way].locked);

    assert_all_locked_no_fill_R11: assert property (@(posedge clk) disable iff (rst)
        (st_q == S_LOOK && cach_q && !hit && !vic_ok) |=> (st_q != S_FILL && st_q != S_EVICT));

endmodule

// File: tb/tb_dc_top.sv
module tb_dc_top;
    import dc_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;  // 125 MHz

    logic        cpu_req = 0, cpu_cacheable = 0, cpu_wthru = 0;
    logic [2:0]  cpu_op = 0;
    logic [31:0] cpu_addr = 0;
    logic [63:0] cpu_wdata = 0;
    logic        cpu_ready, cpu_hit;
    logic [63:0] cpu_rdata;
    logic        bus_req, bus_we;
    logic [31:0] bus_addr, bus_wdata;
    logic        bus_ack = 0;
    logic [31:0] bus_rdata = 0;

    dc_top dut (
        .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_op(cpu_op), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_cacheable(cpu_cacheable), .cpu_wthru(cpu_wthru),
        .cpu_ready(cpu_ready), .cpu_hit(cpu_hit), .cpu_rdata(cpu_rdata),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata)
    );

    int vectors = 0;
    int fails   = 0;

    task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Bus-side memory and the processor-visible memory
    logic [31:0] mem    [logic [31:0]];
    logic [63:0] shadow [logic [31:0]];

    function automatic logic [31:0] init_word(logic [31:0] a);
        return (a * 32'h9E37_79B1) ^ 32'h1234_5678;
    endfunction
    function automatic logic [31:0] mem_rd(logic [31:0] a);
        return mem.exists(a) ? mem[a] : init_word(a);
    endfunction
    function automatic logic [63:0] cpu_view(logic [31:0] a);
        return shadow.exists(a) ? shadow[a] : {init_word(a + 4), init_word(a)};
    endfunction

    // Bus responder with random stalls; R12 hold check on every stall
    int bus_words = 0;
    bit hold_req = 0, hold_we = 0;
    logic [31:0] hold_addr = 0, hold_wd = 0;
    always @(negedge clk) begin
        if (rst) begin
            bus_ack  = 0;
            hold_req = 0;
        end else begin
            if (hold_req)
                check(bus_req && bus_addr == hold_addr && bus_we == hold_we &&
                      (!bus_we || bus_wdata == hold_wd), "R12 stalled transfer held",
                      {31'b0, bus_req, bus_addr}, {32'h1, hold_addr});
            if (bus_req && ($urandom % 4 != 0)) begin
                bus_ack = 1;
                if (bus_we) mem[bus_addr] = bus_wdata;
                else        bus_rdata = mem_rd(bus_addr);
                bus_words++;
                hold_req = 0;
            end else begin
                bus_ack   = 0;
                hold_req  = bus_req;
                hold_addr = bus_addr;
                hold_we   = bus_we;
                hold_wd   = bus_wdata;
            end
        end
    end

    // Requirement model of the cache contents
    bit          mv [128][4];
    bit          md [128][4];
    bit          ml [128][4];
    logic [19:0] mt [128][4];
    int          ms [128][4];
    int          stamp = 0;

    task automatic apply(op_e op, logic [31:0] a, bit c, bit wt, logic [63:0] wd);
        int s = int'(a[11:5]);
        logic [19:0] t = a[31:12];
        logic [31:0] da = {a[31:3], 3'b000};
        int hw = -1, vw = -1, exp_words = 0, cyc = 0;
        bit exp_hit = 0;
        logic [31:0] ev = 0;
        bit evicted = 0;
        logic [63:0] prev_rd;
        string tg;
        if (c) for (int w = 0; w < 4; w++) if (mv[s][w] && mt[s][w] == t) hw = w;
        tg = "R8 uncached";
        if (!c) begin
            exp_words = (op == OP_LOAD || op == OP_STORE) ? 2 : 0;
        end else if (op == OP_STORE) begin
            if (hw >= 0) begin
                exp_hit = 1; ms[s][hw] = ++stamp;
                if (wt) begin exp_words = 2; tg = "R6 write-through hit"; end
                else begin md[s][hw] = 1; tg = "R6 writeback hit"; end
            end else begin
                exp_words = 2; tg = "R7 store miss";
            end
        end else if (op == OP_UNLOCK) begin
            tg = "R10 unlock";
            if (hw >= 0) begin exp_hit = 1; ml[s][hw] = 0; end
        end else if (hw >= 0) begin
            exp_hit = 1; ms[s][hw] = ++stamp; tg = "R2 read hit";
            if (op == OP_LOCK) begin ml[s][hw] = 1; tg = "R10 lock hit"; end
        end else begin
            for (int w = 3; w >= 0; w--) if (!ml[s][w] && !mv[s][w]) vw = w;
            if (vw < 0)
                for (int w = 0; w < 4; w++)
                    if (!ml[s][w] && (vw < 0 || ms[s][w] < ms[s][vw])) vw = w;
            if (vw < 0) begin
                exp_words = (op == OP_LOAD) ? 2 : 0; tg = "R11 all ways locked";
            end else begin
                exp_words = 8; tg = "R3 line fill";
                if (mv[s][vw] && md[s][vw]) begin
                    exp_words = 16; evicted = 1; tg = "R4 dirty eviction";
                    ev = {mt[s][vw], 7'(s), 5'b0};
                end
                mv[s][vw] = 1; md[s][vw] = 0; mt[s][vw] = t;
                ml[s][vw] = (op == OP_LOCK); ms[s][vw] = ++stamp;
            end
        end
        @(negedge clk);
        cpu_req = 1; cpu_op = op; cpu_addr = a; cpu_cacheable = c; cpu_wthru = wt; cpu_wdata = wd;
        bus_words = 0;
        prev_rd = cpu_rdata;
        @(negedge clk);
        cpu_req = 0;
        while (!cpu_ready && cyc < 500) begin @(negedge clk); cyc++; end
        check(cyc < 500, {tg, " completion"}, 64'(cyc), 0);
        check(cpu_hit == exp_hit, {"R5 hit flag / ", tg}, 64'(cpu_hit), 64'(exp_hit));
        check(bus_words == exp_words, {tg, " bus word count"}, 64'(bus_words), 64'(exp_words));
        if (op == OP_LOAD)
            check(cpu_rdata == cpu_view(da), {"R1 load data / ", tg}, cpu_rdata, cpu_view(da));
        if (op == OP_PREF)
            check(cpu_rdata == prev_rd, "R9 prefetch leaves data", cpu_rdata, prev_rd);
        if (evicted)
            for (int k = 0; k < 4; k++)
                check({mem_rd(ev + 8*k + 4), mem_rd(ev + 8*k)} == cpu_view(ev + 8*k),
                      "R4 written-back line contents",
                      {mem_rd(ev + 8*k + 4), mem_rd(ev + 8*k)}, cpu_view(ev + 8*k));
        if (op == OP_STORE) shadow[da] = wd;
    endtask

    function automatic logic [31:0] caddr(int s, int t, int d);
        return {20'(t), 7'(s), 2'(d), 3'b000};
    endfunction

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check(!cpu_ready && !cpu_hit && cpu_rdata == 0, "R2 reset outputs",
              {cpu_ready, cpu_hit}, 0);
        check(!bus_req, "R12 reset bus idle", 64'(bus_req), 0);

        // Directed: fills, hit, writeback, eviction, pinning, store miss, bypass
        apply(OP_LOAD,  caddr(10, 1, 2), 1, 0, 0);
        apply(OP_LOAD,  caddr(10, 1, 3), 1, 0, 0);
        apply(OP_STORE, caddr(10, 1, 0), 1, 0, 64'hDEAD_BEEF_0123_4567);
        apply(OP_LOAD,  caddr(10, 2, 0), 1, 0, 0);
        apply(OP_LOAD,  caddr(10, 3, 0), 1, 0, 0);
        apply(OP_LOAD,  caddr(10, 4, 0), 1, 0, 0);
        apply(OP_LOAD,  caddr(10, 5, 1), 1, 0, 0);
        for (int t = 2; t <= 5; t++) apply(OP_LOCK, caddr(10, t, 0), 1, 0, 0);
        apply(OP_LOAD,  caddr(10, 7, 0), 1, 0, 0);
        apply(OP_PREF,  caddr(10, 8, 0), 1, 0, 0);
        apply(OP_LOCK,  caddr(10, 8, 0), 1, 0, 0);
        apply(OP_UNLOCK, caddr(10, 3, 0), 1, 0, 0);
        apply(OP_UNLOCK, caddr(10, 9, 0), 1, 0, 0);
        apply(OP_LOAD,  caddr(10, 7, 2), 1, 0, 0);
        apply(OP_STORE, caddr(10, 9, 1), 1, 0, 64'h1111_2222_3333_4444);
        apply(OP_LOAD,  caddr(10, 9, 1), 1, 0, 0);
        apply(OP_STORE, caddr(10, 7, 2), 1, 1, 64'h5555_6666_7777_8888);
        apply(OP_LOAD,  caddr(10, 7, 2), 1, 0, 0);
        apply(OP_STORE, 32'h8000_0040, 0, 0, 64'hAAAA_BBBB_CCCC_DDDD);
        apply(OP_LOAD,  32'h8000_0040, 0, 0, 0);
        apply(OP_PREF,  32'h8000_0080, 0, 0, 0);

        // Random traffic confined to two sets and six tags
        for (int i = 0; i < 1500; i++) begin
            int r   = int'($urandom % 100);
            int s   = ($urandom % 2) ? 3 : 77;
            int t   = int'($urandom % 6);
            int d   = int'($urandom % 4);
            bit c   = ($urandom % 10) != 0;
            bit wt  = $urandom % 2;
            logic [63:0] wd = {$urandom, $urandom};
            op_e op = (r < 40) ? OP_LOAD : (r < 70) ? OP_STORE : (r < 80) ? OP_PREF :
                      (r < 88) ? OP_LOCK : OP_UNLOCK;
            logic [31:0] a = c ? caddr(s, t, d) : (32'h8000_0000 | {24'($urandom % 64), 3'b000});
            apply(op, a, c, wt, wd);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule